// File: doc/BRIEF.md
# Thread Interrupt Context Register Window

This block holds the interrupt management context of one hardware thread. The context is 64 bytes, split into four rings of 16 bytes. Ring 0 is the user ring, ring 1 the OS ring, ring 2 the pool ring and ring 3 the physical ring. Software reaches the context through a byte-wide window of four pages. Page 0 is the hardware view, page 1 the hypervisor view, page 2 the OS view and page 3 the user view. Each page sees a different set of rings, depending on its privilege.

The OS ring holds three things. The first is a current-priority threshold. The second is a pending-priority set with one bit per active priority (0 to 7). The third is a target identifier slot with a valid flag. An incoming notification carries a block number, a target index and a priority. It is matched against that slot and, on a hit, marks its priority pending. The exception line to the thread is raised when a pending priority is more favoured than the threshold. A lower number is more favoured, and 0xFF means nothing is masked. Reading the acknowledge byte takes the most favoured pending priority and makes it the new threshold.

Top module: `tctx_window`

## Requirements
- R1: After reset every context byte is 0 except the OS threshold byte (offset 0x10), which is 0xFF. exc_out and rsp_valid are low.
- R2: req_addr[7:6] selects the page, req_addr[5:4] the ring and req_addr[3:0] the byte. A read request is answered one cycle later with rsp_valid high and the byte in rsp_rdata. A write stores req_wdata. Page 0 reaches all 64 bytes.
- R3: Page p reaches only rings r with r <= 3 - p. A read of any other ring returns 0 (rsp_valid is still high). A write to any other ring changes nothing.
- R4: The OS threshold byte is at offset 0x10. The OS pending byte is at offset 0x11, with bit k meaning priority k is pending. In the cycle after any update, exc_out is high exactly when the lowest set pending bit index is below the threshold byte, compared as unsigned 8-bit values. With no pending bit set, exc_out is low.
- R5: A reachable read of the OS acknowledge byte (offset 0x12) returns the lowest pending priority, clears its bit and writes it into the threshold byte. After this, exc_out is low unless a notification lands in the same cycle. With nothing pending it returns 0xFF and changes nothing. Writes to offset 0x12 are dropped.
- R6: The OS target slot is a big-endian 32-bit word at offsets 0x14 to 0x17. Bit 31 is the valid flag, bits 22:0 hold the target line, and bits 30:23 are ignored. A notification with block b, index i and priority k sets pending bit k only when the flag is set and the line equals (b << 19) | i.
- R7: In one cycle, a register write or acknowledge is applied first, using the state before the edge, and a matching notification then ORs its pending bit in. The target match uses the slot as it was before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Window access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Page, ring and byte select |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read answer valid |
| rsp_rdata | output | 8 | Read answer byte |
| notify_valid | input | 1 | Incoming notification |
| notify_blk | input | 4 | Notification block number |
| notify_idx | input | 19 | Notification target index |
| notify_prio | input | 3 | Notification priority |
| exc_out | output | 1 | Exception request to the thread |

## Verification
The assertions assume that every request and notification input is at a known value whenever its valid is high. They also assume the valids stay low while reset is applied, because several properties look one cycle back at a request. The bench drives all inputs on the falling edge and holds the valids low through reset. Its random phase only picks addresses and notification fields inside their port widths, so no out-of-range priority or page can reach the block.

// File: rtl/tctx_pkg.sv
`timescale 1ns/1ps
package tctx_pkg;
    localparam int RING_USER = 0;
    localparam int RING_OS   = 1;
    localparam int RING_POOL = 2;
    localparam int RING_PHYS = 3;

    // byte offsets inside the OS ring
    localparam int OS_CUR_PRIO = 0;
    localparam int OS_PEND     = 1;
    localparam int OS_ACK      = 2;
    localparam int OS_SLOT     = 4;

    localparam logic [7:0] PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        PG_HW   = 2'd0,
        PG_HV   = 2'd1,
        PG_OS   = 2'd2,
        PG_USER = 2'd3
    } page_e;
endpackage

// File: rtl/tctx_access_gate.sv
`timescale 1ns/1ps
module tctx_access_gate #(
    parameter int RING_N = 4,
    parameter int RING_W = 2
) (
    input  logic [RING_W-1:0] page,
    input  logic [RING_W-1:0] ring,
    output logic              allow
);
    localparam logic [RING_W-1:0] TOP_RING = RING_W'(RING_N - 1);

    // a page of privilege p reaches rings up to TOP_RING - p
    assign allow = (ring <= (TOP_RING - page));
endmodule

// File: rtl/tctx_prio_pick.sv
`timescale 1ns/1ps
module tctx_prio_pick #(
    parameter int PRIO_N = 8,
    parameter int PRIO_W = 3
) (
    input  logic [PRIO_N-1:0] pend,
    output logic              found,
    output logic [PRIO_W-1:0] idx
);
    logic [PRIO_N-1:0] first;

    generate
        for (genvar i = 0; i < PRIO_N; i++) begin : g_first
            localparam logic [PRIO_N-1:0] LOWER = (PRIO_N'(1) << i) - PRIO_N'(1);
            assign first[i] = pend[i] && ((pend & LOWER) == '0);
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int k = 0; k < PRIO_N; k++) begin
            if (first[k]) begin
                idx = PRIO_W'(k);
            end
        end
    end

    assign found = |pend;
endmodule

// File: rtl/tctx_cam_match.sv
`timescale 1ns/1ps
module tctx_cam_match #(
    parameter int BLK_W = 4,
    parameter int IDX_W = 19
) (
    input  logic [31:0]      slot,
    input  logic [BLK_W-1:0] blk,
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    localparam int CAM_W = BLK_W + IDX_W;

    logic [CAM_W-1:0] line;

    assign line = (CAM_W'(blk) << IDX_W) | CAM_W'(idx);
    assign hit  = slot[31] && (slot[CAM_W-1:0] == line);
endmodule

// File: rtl/tctx_window.sv
`timescale 1ns/1ps
module tctx_window
    import tctx_pkg::*;
#(
    parameter int RING_N     = 4,
    parameter int RING_BYTES = 16,
    parameter int PRIO_N     = 8,
    parameter int BLK_W      = 4,
    parameter int IDX_W      = 19,
    localparam int RING_W    = $clog2(RING_N),
    localparam int BYTE_W    = $clog2(RING_BYTES),
    localparam int ADDR_W    = 2 * RING_W + BYTE_W,
    localparam int PRIO_W    = $clog2(PRIO_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    input  logic              notify_valid,
    input  logic [BLK_W-1:0]  notify_blk,
    input  logic [IDX_W-1:0]  notify_idx,
    input  logic [PRIO_W-1:0] notify_prio,
    output logic              exc_out
);
    localparam int CTX_BYTES = RING_N * RING_BYTES;
    localparam int FLAT_W    = RING_W + BYTE_W;
    localparam int CUR_IX    = RING_OS * RING_BYTES + OS_CUR_PRIO;
    localparam int PEND_IX   = RING_OS * RING_BYTES + OS_PEND;
    localparam int SLOT_IX   = RING_OS * RING_BYTES + OS_SLOT;

    typedef struct packed {
        logic [CTX_BYTES-1:0][7:0] ctx;
        logic                      rsp_v;
        logic [7:0]                rdata;
        logic                      exc;
    } st_t;

    st_t st_q, st_mid, st_d;

    // address split
    logic [RING_W-1:0] pg, rg;
    logic [BYTE_W-1:0] by;
    logic [FLAT_W-1:0] flat;
    logic              is_ack;

    assign {pg, rg, by} = req_addr;
    assign flat         = {rg, by};
    assign is_ack       = (rg == RING_W'(RING_OS)) && (by == BYTE_W'(OS_ACK));

    logic allow;
    tctx_access_gate #(.RING_N(RING_N), .RING_W(RING_W)) u_gate (
        .page (pg),
        .ring (rg),
        .allow(allow)
    );

    logic              now_found;
    logic [PRIO_W-1:0] now_idx;
    tctx_prio_pick #(.PRIO_N(PRIO_N), .PRIO_W(PRIO_W)) u_pick_now (
        .pend (st_q.ctx[PEND_IX][PRIO_N-1:0]),
        .found(now_found),
        .idx  (now_idx)
    );

    logic [31:0] slot_word;
    logic        cam_hit;
    assign slot_word = {st_q.ctx[SLOT_IX], st_q.ctx[SLOT_IX+1],
                        st_q.ctx[SLOT_IX+2], st_q.ctx[SLOT_IX+3]};

    tctx_cam_match #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_cam (
        .slot(slot_word),
        .blk (notify_blk),
        .idx (notify_idx),
        .hit (cam_hit)
    );

    // access and notification step
    always_comb begin
        st_mid       = st_q;
        st_mid.rsp_v = 1'b0;
        st_mid.rdata = '0;
        if (req_valid) begin
            if (!req_write) begin
                st_mid.rsp_v = 1'b1;
                if (allow) begin
                    if (is_ack) begin
                        if (now_found) begin
                            st_mid.rdata                  = 8'(now_idx);
                            st_mid.ctx[PEND_IX][now_idx]  = 1'b0;
                            st_mid.ctx[CUR_IX]            = 8'(now_idx);
                        end else begin
                            st_mid.rdata = PRIO_NONE;
                        end
                    end else begin
                        st_mid.rdata = st_q.ctx[flat];
                    end
                end
            end else if (allow && !is_ack) begin
                st_mid.ctx[flat] = req_wdata;
            end
        end
        if (notify_valid && cam_hit) begin
            st_mid.ctx[PEND_IX][notify_prio] = 1'b1;
        end
    end

    logic              nxt_found;
    logic [PRIO_W-1:0] nxt_idx;
    tctx_prio_pick #(.PRIO_N(PRIO_N), .PRIO_W(PRIO_W)) u_pick_nxt (
        .pend (st_mid.ctx[PEND_IX][PRIO_N-1:0]),
        .found(nxt_found),
        .idx  (nxt_idx)
    );

    // exception decision on the updated state
    always_comb begin
        st_d     = st_mid;
        st_d.exc = nxt_found && (8'(nxt_idx) < st_mid.ctx[CUR_IX]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.ctx[CUR_IX]  <= PRIO_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rdata;
    assign exc_out   = st_q.exc;

    // observation points for the bound checker
    logic [7:0] cur_prio;
    logic [7:0] pend_set;
    assign cur_prio = st_q.ctx[CUR_IX];
    assign pend_set = st_q.ctx[PEND_IX];
endmodule

// File: rtl/tctx_window_chk.sv
`timescale 1ns/1ps
module tctx_window_chk #(
    parameter int RING_N = 4,
    parameter int RING_W = 2,
    parameter int BYTE_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_write,
    input logic [2*RING_W+BYTE_W-1:0]    req_addr,
    input logic                          rsp_valid,
    input logic [7:0]                    rsp_rdata,
    input logic                          notify_valid,
    input logic                          exc_out,
    input logic [7:0]                    cur_prio,
    input logic [7:0]                    pend_set
);
    logic [RING_W-1:0] c_pg, c_rg;
    logic [BYTE_W-1:0] c_by;
    logic              c_rd, c_reach, c_ack;

    assign {c_pg, c_rg, c_by} = req_addr;
    assign c_rd    = req_valid && !req_write;
    assign c_reach = (int'(c_rg) + int'(c_pg)) <= (RING_N - 1);
    assign c_ack   = (c_rg == RING_W'(1)) && (c_by == BYTE_W'(2));

    // R2: every read gets an answer next cycle
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd |=> rsp_valid);

    // R2: no answer without a read
    a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rd |=> !rsp_valid);

    // R3: unreachable ring reads as zero
    a_r3_denied_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && !c_reach) |=> (rsp_rdata == 8'h00));

    // R5: acknowledge returns an active priority or the empty code
    a_r5_ack_value_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && c_reach && c_ack) |=> ((rsp_rdata < 8'd8) || (rsp_rdata == 8'hFF)));

    // R5: acknowledge without a concurrent notification drops the line
    a_r5_ack_drops_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && c_reach && c_ack && !notify_valid) |=> !exc_out);

    // R4: raised line implies something pending
    a_r4_exc_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        exc_out |-> (pend_set != 8'h00));

    // R4: threshold zero masks everything
    a_r4_exc_needs_open_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        exc_out |-> (cur_prio != 8'h00));
endmodule

bind tctx_window tctx_window_chk #(
    .RING_N(RING_N),
    .RING_W(RING_W),
    .BYTE_W(BYTE_W)
) u_chk (.*);

// File: tb/tctx_window_bench.sv
`timescale 1ns/1ps
module tctx_window_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr, req_wdata;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        notify_valid;
    logic [3:0]  notify_blk;
    logic [18:0] notify_idx;
    logic [2:0]  notify_prio;
    logic        exc_out;

    always #2 clk = ~clk;

    tctx_window u_tctx_window (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .notify_valid(notify_valid), .notify_blk(notify_blk),
        .notify_idx(notify_idx), .notify_prio(notify_prio),
        .exc_out(exc_out)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_req = "R1";

    logic [7:0] mem [64];
    logic       exp_rsp;
    logic [7:0] exp_rd;
    logic       exp_exc;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int k = 0; k < 8; k++) if (v[k]) return k;
        return 255;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 64; k++) mem[k] = 8'h00;
        mem[16] = 8'hFF;
        exp_rsp = 0; exp_rd = 0; exp_exc = 0;
    endtask

    task automatic model_step();
        int pg = int'(req_addr) / 64;
        int rg = (int'(req_addr) / 16) % 4;
        int fl = int'(req_addr) % 64;
        bit reach = (rg + pg) <= 3;
        logic [31:0] slot = {mem[20], mem[21], mem[22], mem[23]};
        int line = int'(notify_blk) * 524288 + int'(notify_idx);
        bit hit = slot[31] && (int'(slot[22:0]) == line);
        int lo = lowest(mem[17]);
        exp_rsp = 0;
        exp_rd  = 0;
        if (req_valid) begin
            if (!req_write) begin
                exp_rsp = 1;
                if (reach) begin
                    if (fl == 18) begin
                        if (lo < 8) begin
                            exp_rd = 8'(lo);
                            mem[17][lo] = 1'b0;
                            mem[16] = 8'(lo);
                        end else begin
                            exp_rd = 8'hFF;
                        end
                    end else begin
                        exp_rd = mem[fl];
                    end
                end
            end else if (reach && fl != 18) begin
                mem[fl] = req_wdata;
            end
        end
        if (notify_valid && hit) mem[17][notify_prio] = 1'b1;
        lo = lowest(mem[17]);
        exp_exc = (lo < 8) && (lo < int'(mem[16]));
    endtask

    task automatic compare();
        chk(rsp_valid === exp_rsp, cur_req, "rsp_valid", int'(rsp_valid), int'(exp_rsp));
        chk(rsp_rdata === exp_rd,  cur_req, "rsp_rdata", int'(rsp_rdata), int'(exp_rd));
        chk(exc_out === exp_exc,   cur_req, "exc_out",   int'(exc_out),   int'(exp_exc));
    endtask

    task automatic op(input bit v, input bit w, input int addr, input int wd,
                      input bit nv, input int blk, input int idx, input int pr);
        req_valid    = v;
        req_write    = w;
        req_addr     = 8'(addr);
        req_wdata    = 8'(wd);
        notify_valid = nv;
        notify_blk   = 4'(blk);
        notify_idx   = 19'(idx);
        notify_prio  = 3'(pr);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        req_valid    = 0;
        notify_valid = 0;
    endtask

    task automatic rd(input int pg, input int fl);
        op(1, 0, pg * 64 + fl, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input int pg, input int fl, input int d);
        op(1, 1, pg * 64 + fl, d, 0, 0, 0, 0);
    endtask
    task automatic note(input int blk, input int idx, input int pr);
        op(0, 0, 0, 0, 1, blk, idx, pr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        notify_valid = 0; notify_blk = 0; notify_idx = 0; notify_prio = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        chk(exc_out === 1'b0, "R1", "exc_out", int'(exc_out), 0);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
        for (int k = 0; k < 64; k++) if (k != 18) rd(0, k);
        rd(0, 16);
        chk(rsp_rdata === 8'hFF, "R1", "threshold", int'(rsp_rdata), 'hFF);

        // R2 full access from page 0
        cur_req = "R2";
        wr(0, 37, 'hA5);
        rd(0, 37);
        chk(rsp_rdata === 8'hA5, "R2", "readback", int'(rsp_rdata), 'hA5);
        for (int k = 0; k < 64; k++) if (k != 16 && k != 17 && k != 18 && (k < 20 || k > 23)) wr(0, k, k * 7 + 3);
        for (int k = 0; k < 64; k++) if (k != 18) rd(0, k);

        // R3 privilege rings
        cur_req = "R3";
        wr(3, 'h35, 'h5A);
        rd(3, 'h35);
        chk(rsp_rdata === 8'h00, "R3", "user page to phys ring", int'(rsp_rdata), 0);
        rd(0, 'h35);
        chk(rsp_rdata === 8'(('h35) * 7 + 3), "R3", "dropped write", int'(rsp_rdata), ('h35 * 7 + 3) % 256);
        wr(3, 'h03, 'h11);
        rd(3, 'h03);
        chk(rsp_rdata === 8'h11, "R3", "user page own ring", int'(rsp_rdata), 'h11);
        for (int p = 1; p < 4; p++)
            for (int k = 0; k < 64; k++)
                if (k < 16 || k > 23) begin wr(p, k, p * 16 + k); rd(p, k); end

        // R6 target match
        cur_req = "R6";
        wr(2, 20, 'h80); wr(2, 21, 'h29); wr(2, 22, 'h23); wr(2, 23, 'h45);
        note(5, 'h12345, 3);
        chk(exc_out === 1'b1, "R6", "exc after match", int'(exc_out), 1);
        note(5, 'h12344, 1);
        rd(0, 17);
        chk(rsp_rdata === 8'h08, "R6", "mismatch ignored", int'(rsp_rdata), 'h08);
        wr(0, 20, 'h7F);
        note(5, 'h12345, 0);
        rd(0, 17);
        chk(rsp_rdata === 8'h08, "R6", "invalid slot ignored", int'(rsp_rdata), 'h08);
        wr(0, 20, 'hFF);
        note(5, 'h12345, 6);

        // R5 acknowledge
        cur_req = "R5";
        rd(2, 18);
        chk(rsp_rdata === 8'h03, "R5", "first ack", int'(rsp_rdata), 3);
        chk(exc_out === 1'b0, "R5", "exc after ack", int'(exc_out), 0);
        rd(0, 16);
        chk(rsp_rdata === 8'h03, "R5", "threshold after ack", int'(rsp_rdata), 3);
        rd(1, 18);
        chk(rsp_rdata === 8'h06, "R5", "second ack", int'(rsp_rdata), 6);
        rd(2, 18);
        chk(rsp_rdata === 8'hFF, "R5", "empty ack", int'(rsp_rdata), 'hFF);
        rd(0, 16);
        chk(rsp_rdata === 8'h06, "R5", "empty ack keeps threshold", int'(rsp_rdata), 6);
        note(5, 'h12345, 2);
        rd(3, 18);
        chk(rsp_rdata === 8'h00, "R5", "user page ack denied", int'(rsp_rdata), 0);
        wr(0, 18, 'h00);
        rd(0, 17);
        chk(rsp_rdata === 8'h04, "R5", "ack write dropped", int'(rsp_rdata), 4);

        // R4 threshold compare
        cur_req = "R4";
        wr(2, 16, 2);
        chk(exc_out === 1'b0, "R4", "equal threshold", int'(exc_out), 0);
        wr(2, 16, 3);
        chk(exc_out === 1'b1, "R4", "threshold above", int'(exc_out), 1);
        wr(2, 16, 0);
        chk(exc_out === 1'b0, "R4", "threshold zero", int'(exc_out), 0);
        wr(2, 16, 'hFF);
        chk(exc_out === 1'b1, "R4", "threshold open", int'(exc_out), 1);

        // R7 same-cycle ordering
        cur_req = "R7";
        op(1, 0, 2 * 64 + 18, 0, 1, 5, 'h12345, 0);
        chk(rsp_rdata === 8'h02, "R7", "ack with notify", int'(rsp_rdata), 2);
        chk(exc_out === 1'b1, "R7", "notify beats new threshold", int'(exc_out), 1);
        op(1, 1, 17, 'h80, 1, 5, 'h12345, 1);
        rd(0, 17);
        chk(rsp_rdata === 8'h82, "R7", "write then notify", int'(rsp_rdata), 'h82);
        op(1, 1, 20, 'h00, 1, 5, 'h12345, 4);
        rd(0, 17);
        chk(rsp_rdata === 8'h92, "R7", "old slot used", int'(rsp_rdata), 'h92);

        // mixed traffic
        cur_req = "R2/R4/R5/R6";
        wr(0, 20, 'h80);
        for (int n = 0; n < 4000; n++) begin
            int sel  = int'($urandom_range(0, 9));
            int pg   = int'($urandom_range(0, 3));
            int fl   = (sel < 6) ? int'($urandom_range(16, 18)) : int'($urandom_range(0, 63));
            bit nv   = ($urandom_range(0, 2) == 0);
            int idx  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 'h7FFFF)) : 'h12345;
            bit w    = (sel >= 3) && (fl != 20);
            int d    = (fl == 16) ? int'($urandom_range(0, 9)) : int'($urandom_range(0, 255));
            op(1, w, pg * 64 + fl, d, nv, 5, idx, int'($urandom_range(0, 7)));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule